// File: doc/BRIEF.md
# Set/Clear Control and Status Register

This block is a 32-bit control and status register that sits at address zero of a bus slave. Ten single-bit control levels drive the surrounding logic: crate selection for the reset bus, run enable, reset-bus drive, service-request selection and drive, single step, keep-alive, segment selection, cable service-request enable and timeout inhibit. Software never rewrites a level directly. It writes a 1 to a "set" position in the low half or to a "clear" position in the high half, and every bit written as 0 leaves its level as it is. Several control bits can therefore be changed in one write with no read-modify-write.

The same write can fire a one-clock start pulse and can load a 4-bit class value, but the class value loads only when a separate enable bit is also 1 in that write. A read returns the control levels and the class value in the low half. The high half is a fixed identifier, 0x0106.

Top module: `csr_setclr_reg`

## Requirements
- R1: During and after reset, all ten control levels, `class_val` and `start_pulse` are 0, and `rd_data` is 0 until the first read.
- R2: When `wr_en` is 1 at a clock edge and `wr_data[i]` is 1 (i = 1..10), the level mapped to bit i is 1 after that edge. The mapping is: 1 crate_sel_rb, 2 run_en, 3 rb_assert, 4 sr_sel, 5 sr_assert, 6 step_en, 7 keepalive_en, 8 seg_sel, 9 cable_sr_en, 10 tmo_inhibit.
- R3: A write with 1 in a clear position sets the mapped level to 0. For bits 1..3 and 5..8 the clear position is i+16. Bit 9 is cleared by bit 20 or by bit 25. Bit 10 is cleared by bit 26. Bit 4 has no clear position. If a set bit and its clear bit are both 1 in one write, the level ends at 0.
- R4: A 0 in any write-data bit leaves the matching state unchanged. Write-data bits 0 and 27..31 have no effect. With `wr_en` low, nothing changes.
- R5: A read image has these fields: bit 0 = 0, bits 1..10 = the levels, bit 11 = 0, bits 15:12 = the class value, bits 31:16 = 0x0106. At reset the high half of that image shows only bits 17, 18 and 24 set.
- R6: `start_pulse` is 1 for exactly the one clock cycle after each edge at which `wr_en` and `wr_data[11]` are both 1. Otherwise it is 0, and it is never stored.
- R7: `class_val` loads `wr_data[15:12]` only on a write that also has `wr_data[16]` = 1. Any other write leaves it unchanged.
- R8: When `rd_en` is 1 at an edge, `rd_data` takes the image of the state as it was before that edge, so a write in the same cycle is not yet seen. It then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data (set/clear/start/class bits) |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Registered read image |
| crate_sel_rb | output | 1 | Crate selected for reset bus |
| run_en | output | 1 | Run enabled |
| rb_assert | output | 1 | Reset bus driven |
| sr_sel | output | 1 | Selected for service request |
| sr_assert | output | 1 | Service request driven |
| step_en | output | 1 | Single step enabled |
| keepalive_en | output | 1 | Keep-alive enabled |
| seg_sel | output | 1 | Crate segment selected |
| cable_sr_en | output | 1 | Cable service request enabled |
| tmo_inhibit | output | 1 | Timeout inhibited |
| start_pulse | output | 1 | One-cycle start strobe |
| class_val | output | 4 | Stored class value |

## Verification
Every result is due one edge after the stimulus that caused it. The levels, `class_val` and `start_pulse` change at the edge that samples the write, and `rd_data` changes at the edge that samples `rd_en`. The bench drives its inputs on the falling clock edge and checks on the next falling edge, which puts every check half a period after the one register stage involved. To confirm that `start_pulse` lasts one cycle, the bench checks that it is low again one falling edge later. To confirm that a read returns the state from before the edge, a read is issued in the same cycle as a write, and the next read must show the write.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int REG_W        = 32;
    localparam int HALF_W       = REG_W / 2;
    localparam int CTRL_LO      = 1;
    localparam int CTRL_HI      = 10;
    localparam int NUM_CTRL     = CTRL_HI - CTRL_LO + 1;
    localparam int START_BIT    = 11;
    localparam int CLASS_LSB    = 12;
    localparam int CLASS_W      = 4;
    localparam int CLASS_EN_BIT = 16;
    localparam logic [HALF_W-1:0] MFG_ID = 16'h0106;

    // Clear positions of each control bit. Bit 4 has none; bit 9 has two.
    function automatic logic [REG_W-1:0] clear_mask(input int idx);
        logic [REG_W-1:0] m;
        m = '0;
        if (idx == 4) begin
            m = '0;
        end else if (idx == 9) begin
            m[20] = 1'b1;
            m[25] = 1'b1;
        end else begin
            m[idx + HALF_W] = 1'b1;
        end
        return m;
    endfunction

    typedef struct packed {
        logic             start;
        logic [REG_W-1:0] rd;
    } top_state_t;
endpackage

// File: rtl/csr_ctrl_bit.sv
module csr_ctrl_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic level_o
);
    logic level_d;
    logic level_q;

    always_comb begin
        level_d = level_q;
        if (clr_i) begin
            level_d = 1'b0;
        end else if (set_i) begin
            level_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end

    assign level_o = level_q;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> level_o); // R2
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !level_o); // R3
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(level_o)); // R4
endmodule

// File: rtl/csr_class_field.sv
module csr_class_field
    import csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [CLASS_W-1:0] val_i,
    output logic [CLASS_W-1:0] cls_o
);
    logic [CLASS_W-1:0] cls_d;
    logic [CLASS_W-1:0] cls_q;

    always_comb begin
        cls_d = cls_q;
        if (load_i) begin
            cls_d = val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= '0;
        end else begin
            cls_q <= cls_d;
        end
    end

    assign cls_o = cls_q;

    AST_CLASS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cls_o)); // R7
    AST_CLASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cls_o == $past(val_i))); // R7
endmodule

// File: rtl/csr_read_image.sv
module csr_read_image
    import csr_pkg::*;
(
    input  logic [CTRL_HI:CTRL_LO] levels_i,
    input  logic [CLASS_W-1:0]     cls_i,
    output logic [REG_W-1:0]       img_o
);
    always_comb begin
        img_o                                = '0;
        img_o[CTRL_HI:CTRL_LO]               = levels_i;
        img_o[CLASS_LSB +: CLASS_W]          = cls_i;
        img_o[REG_W-1:HALF_W]                = MFG_ID;
    end
endmodule

// File: rtl/csr_setclr_reg.sv
module csr_setclr_reg
    import csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_en,
    output logic [REG_W-1:0]   rd_data,
    output logic               crate_sel_rb,
    output logic               run_en,
    output logic               rb_assert,
    output logic               sr_sel,
    output logic               sr_assert,
    output logic               step_en,
    output logic               keepalive_en,
    output logic               seg_sel,
    output logic               cable_sr_en,
    output logic               tmo_inhibit,
    output logic               start_pulse,
    output logic [CLASS_W-1:0] class_val
);
    logic [CTRL_HI:CTRL_LO] set_hit;
    logic [CTRL_HI:CTRL_LO] clr_hit;
    logic [CTRL_HI:CTRL_LO] levels;
    logic [REG_W-1:0]       image;
    logic                   class_load;
    logic                   unused_wr_bits;
    top_state_t             st_d;
    top_state_t             st_q;

    assign unused_wr_bits = ^{wr_data[0], wr_data[REG_W-1:27]};

    for (genvar gi = CTRL_LO; gi <= CTRL_HI; gi++) begin : g_ctrl
        localparam logic [REG_W-1:0] CLR_M = clear_mask(gi);
        assign set_hit[gi] = wr_en & wr_data[gi];
        assign clr_hit[gi] = wr_en & (|(wr_data & CLR_M));
        csr_ctrl_bit i_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_hit[gi]),
            .clr_i   (clr_hit[gi]),
            .level_o (levels[gi])
        );
    end

    assign class_load = wr_en & wr_data[CLASS_EN_BIT];

    csr_class_field i_class (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (class_load),
        .val_i  (wr_data[CLASS_LSB +: CLASS_W]),
        .cls_o  (class_val)
    );

    csr_read_image i_image (
        .levels_i (levels),
        .cls_i    (class_val),
        .img_o    (image)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = wr_en & wr_data[START_BIT];
        if (rd_en) begin
            st_d.rd = image;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data      = st_q.rd;
    assign start_pulse  = st_q.start;
    assign crate_sel_rb = levels[1];
    assign run_en       = levels[2];
    assign rb_assert    = levels[3];
    assign sr_sel       = levels[4];
    assign sr_assert    = levels[5];
    assign step_en      = levels[6];
    assign keepalive_en = levels[7];
    assign seg_sel      = levels[8];
    assign cable_sr_en  = levels[9];
    assign tmo_inhibit  = levels[10];

    AST_START_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[START_BIT]) |=> start_pulse); // R6
    AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[START_BIT]) |=> !start_pulse); // R6
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R8
    AST_ID_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data[REG_W-1:HALF_W] == MFG_ID)); // R5
    AST_NO_SR_SEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(sr_sel) == 1'b1 && sr_sel == 1'b1) |=> sr_sel); // R3
endmodule

// File: tb/test_csr_setclr_reg.sv
`timescale 1ns/1ps
module test_csr_setclr_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        crate_sel_rb, run_en, rb_assert, sr_sel, sr_assert;
    logic        step_en, keepalive_en, seg_sel, cable_sr_en, tmo_inhibit;
    logic        start_pulse;
    logic [3:0]  class_val;

    int checks = 0;
    int failures = 0;
    logic [10:1] m_lv = '0;
    logic [3:0]  m_cls = '0;

    always #10 clk = ~clk;

    csr_setclr_reg i_csr_setclr_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .crate_sel_rb(crate_sel_rb), .run_en(run_en), .rb_assert(rb_assert),
        .sr_sel(sr_sel), .sr_assert(sr_assert), .step_en(step_en),
        .keepalive_en(keepalive_en), .seg_sel(seg_sel),
        .cable_sr_en(cable_sr_en), .tmo_inhibit(tmo_inhibit),
        .start_pulse(start_pulse), .class_val(class_val)
    );

    function automatic logic [10:1] obs_levels();
        return {tmo_inhibit, cable_sr_en, seg_sel, keepalive_en, step_en,
                sr_assert, sr_sel, rb_assert, run_en, crate_sel_rb};
    endfunction

    function automatic logic [31:0] clr_of(int i);
        logic [31:0] m = '0;
        if (i == 9) m = 32'h0210_0000;
        else if (i != 4) m = 32'd1 << (i + 16);
        return m;
    endfunction

    function automatic logic [10:1] model_next(logic [10:1] cur, logic [31:0] d);
        logic [10:1] n = cur;
        for (int i = 1; i <= 10; i++) begin
            if ((d & clr_of(i)) != 0) n[i] = 1'b0;
            else if (d[i]) n[i] = 1'b1;
        end
        return n;
    endfunction

    function automatic logic [31:0] model_img();
        return {16'h0106, m_cls, 1'b0, m_lv, 1'b0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [31:0] d, string req);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        m_lv = model_next(m_lv, d);
        if (d[16]) m_cls = d[15:12];
        check(req, {22'd0, obs_levels()}, {22'd0, m_lv});
        check({req, " start"}, {31'd0, start_pulse}, {31'd0, d[11]});
        check({req, " class"}, {28'd0, class_val}, {28'd0, m_cls});
    endtask

    task automatic do_read(string req);
        logic [31:0] exp;
        exp = model_img();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
        @(negedge clk);
        check({req, " R8 hold"}, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] img_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 levels", {22'd0, obs_levels()}, 32'd0);
        check("R1 class", {28'd0, class_val}, 32'd0);
        check("R1 start", {31'd0, start_pulse}, 32'd0);
        check("R1 rd_data", rd_data, 32'd0);
        do_read("R5 reset image");
        check("R5 reset id bits", rd_data & 32'hFFFF_0000, 32'h0106_0000);

        // R2 each set bit alone
        for (int i = 1; i <= 10; i++) do_write(32'd1 << i, "R2 set");
        do_read("R5 all set image");

        // R3 every high-half position from an all-set state (R4 for 27..31)
        for (int j = 16; j <= 31; j++) begin
            do_write(32'h0000_07FE, "R2 refill");
            do_write(32'd1 << j, (j >= 27) ? "R4 ignored high bit" : "R3 clear");
        end
        // R3 clear wins over set in the same write
        for (int i = 1; i <= 10; i++) begin
            do_write(32'h03FE_0000, "R3 clear all");
            do_write((32'd1 << i) | clr_of(i), "R3 clear wins");
        end

        // R4 zero and ignored bits
        do_write(32'h0000_0556, "R2 pattern");
        do_write(32'h0000_0000, "R4 zero write");
        do_write(32'hF800_0001, "R4 ignored bits");
        @(negedge clk);
        check("R4 wr_en low", {22'd0, obs_levels()}, {22'd0, m_lv});

        // R6 start pulse lasts one cycle
        do_write(32'h0000_0800, "R6 start");
        @(negedge clk);
        check("R6 start drops", {31'd0, start_pulse}, 32'd0);

        // R7 class sweep with and without enable
        for (int v = 0; v < 16; v++) begin
            do_write({15'd0, 1'b1, v[3:0], 12'd0}, "R7 class load");
            do_write({15'd0, 1'b0, ~v[3:0], 12'd0}, "R7 class locked");
            do_read("R5 class image");
        end

        // R8 read and write in the same cycle: read sees pre-write state
        img_before = model_img();
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; wr_data = 32'h03FE_0000;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        m_lv = model_next(m_lv, 32'h03FE_0000);
        check("R8 same-cycle read", rd_data, img_before);
        do_read("R8 next read");

        // mixed pseudo-random writes
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            do_write(lfsr, "R3 random write");
            if (k % 10 == 0) do_read("R5 random read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule